// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the interlock and forwarding controller for a six-step, in-order integer pipeline (address, fetch, decode, execute, memory, writeback). Each cycle it is given the instruction sitting in decode: its two source register numbers with use flags, its destination, and a few class bits. It keeps a small shadow of the instructions that have moved on into execute, memory and writeback. From these it drives the operand forwarding selects for decode. It also drives the hold and bubble strobes that freeze or drain each group of pipeline registers.

Writeback writes the register file in the first half of the cycle, and decode reads it in the second half. Because of this, only the execute and memory producers need forwarding paths. A load whose consumer sits directly behind it costs one bubble. An instruction-cache miss holds the front end until the fetch returns. A data-cache miss on a load freezes the whole pipe only when decode actually needs that load's result; otherwise the pipe keeps moving.

Long multi-cycle instructions (cache maintenance and trap-return classes) stay in execute until the datapath reports completion. The block also raises the control-register write strobe for a control move that has not been nullified. It carries the external trap requests, sampled when an instruction leaves execute, down to writeback.

Top module: `hazard_unit`

## Requirements
- R1: During and right after reset, all shadow stages are empty, and every hold, bubble, select, trap and write output is zero.
- R2: A source operand (use flag set, register not 0, decode valid) that matches the destination of a valid, register-writing instruction in execute gets select 1 (execute result).
- R3: A source that matches a valid writer in memory and has no execute match gets select 2 (memory result). When both stages match, select 1 wins.
- R4: A source gets select 0 (register file) when it is register 0, when its use flag is clear, or when its only producer is in writeback.
- R5: When a valid load in execute writes a register that decode reads, holdFront and bubbleExec are 1 for exactly that cycle. The consumer then sees select 2 on the following cycle.
- R6: While fetchMiss is 1, holdFront and bubbleExec are 1, and execute receives an empty slot.
- R7: While a valid long instruction is in execute and longDone is 0, holdFront, holdExec and bubbleMem are 1 and the long instruction stays in execute. It leaves on the cycle longDone is 1.
- R8: A dataMiss while a valid load in memory writes a register that decode reads sets holdFront, holdExec and holdMem with no bubble. A dataMiss with no such dependency raises no hold.
- R9: wbTrap shows the trapReq bits that were present when the instruction left execute. It shows them two clock edges later, while that instruction is in writeback, and shows zero for empty slots.
- R10: ctlWrite is 1 in a cycle when a valid control move is in execute, exNullify is 0 and execute is not held.
- R11: The stall causes rank data-miss freeze first, then long-instruction hold, then load-use or fetch-miss bubble. Only the outputs of the winning cause are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode holds a real instruction |
| decSrcA | input | 5 | First source register number |
| decUseA | input | 1 | First source is read |
| decSrcB | input | 5 | Second source register number |
| decUseB | input | 1 | Second source is read |
| decDst | input | 5 | Destination register number |
| decWrites | input | 1 | Instruction writes decDst |
| decLoad | input | 1 | Instruction is a load |
| decLong | input | 1 | Instruction is a long multi-cycle kind |
| decCtlMove | input | 1 | Instruction moves a value to a control register |
| fetchMiss | input | 1 | Instruction-cache miss pending for decode |
| dataMiss | input | 1 | Load in memory stage missed the data cache |
| longDone | input | 1 | Long instruction in execute finishes this cycle |
| exNullify | input | 1 | Instruction in execute is nullified |
| trapReq | input | 4 | External trap requests |
| bypassA | output | 2 | Select for source A: 0 file, 1 execute, 2 memory |
| bypassB | output | 2 | Select for source B: same encoding |
| holdFront | output | 1 | Hold address, fetch and decode registers |
| holdExec | output | 1 | Hold execute register |
| holdMem | output | 1 | Hold memory and writeback registers |
| bubbleExec | output | 1 | Load an empty slot into execute |
| bubbleMem | output | 1 | Load an empty slot into memory |
| ctlWrite | output | 1 | Control-register write at end of execute |
| wbTrap | output | 4 | Trap requests of the instruction in writeback |

## Verification
A wrong shadow entry in execute or memory shows on the very next decode that names the affected register. It appears as a wrong select, or as a missing or extra bubble. A lost or duplicated slot moves the trap bits on wbTrap one cycle early or late, and the control write appears or vanishes. The bench therefore compares every output against a behavioural pipeline model on every cycle, so a corrupted stage shows up within the two or three cycles it takes to reach writeback.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int unsigned REG_BITS  = 5;
  localparam int unsigned TRAP_SRCS = 4;
  localparam int unsigned NUM_SRC   = 2;

  typedef enum logic [1:0] {
    SEL_RF = 2'd0,
    SEL_EX = 2'd1,
    SEL_MM = 2'd2
  } bypass_sel_t;

  // Instruction class carried into the execute shadow
  typedef struct packed {
    logic                valid;
    logic [REG_BITS-1:0] dst;
    logic                writes;
    logic                load;
    logic                lengthy;
    logic                ctlMove;
  } stage_info_t;

  // Strobes from control to the stage registers
  typedef struct packed {
    logic holdEx;
    logic holdMem;
    logic bubbleEx;
    logic bubbleMem;
  } stage_ctl_t;
endpackage

// File: rtl/hzd_operand_match.sv
module hzd_operand_match
  import hazard_pkg::*;
#(
  parameter int unsigned RW = REG_BITS
) (
  input  logic          decValid,
  input  logic [RW-1:0] src,
  input  logic          useSrc,
  input  logic          exValid,
  input  logic [RW-1:0] exDst,
  input  logic          exWrites,
  input  logic          mmValid,
  input  logic [RW-1:0] mmDst,
  input  logic          mmWrites,
  output logic          hitEx,
  output logic          hitMm,
  output bypass_sel_t   sel
);
  logic live;

  always_comb begin
    live  = decValid && useSrc && (src != '0);
    hitEx = live && exValid && exWrites && (exDst == src);
    hitMm = live && mmValid && mmWrites && (mmDst == src);
    if (hitEx)      sel = SEL_EX;
    else if (hitMm) sel = SEL_MM;
    else            sel = SEL_RF;
  end
endmodule

// File: rtl/hzd_control.sv
module hzd_control
  import hazard_pkg::*;
#(
  parameter int unsigned RW = REG_BITS,
  parameter int unsigned NS = NUM_SRC
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  decValid,
  input  logic [NS-1:0][RW-1:0] decSrc,
  input  logic [NS-1:0]         decUse,
  input  logic                  exValid,
  input  logic [RW-1:0]         exDst,
  input  logic                  exWrites,
  input  logic                  exLoad,
  input  logic                  exLong,
  input  logic                  mmValid,
  input  logic [RW-1:0]         mmDst,
  input  logic                  mmWrites,
  input  logic                  mmLoad,
  input  logic                  fetchMiss,
  input  logic                  dataMiss,
  input  logic                  longDone,
  output stage_ctl_t            ctl,
  output logic                  holdFront,
  output logic [NS-1:0][1:0]    sel
);
  logic [NS-1:0] hitEx;
  logic [NS-1:0] hitMm;
  logic freeze, longBusy, loadUse;

  for (genvar i = 0; i < NS; i++) begin : g_src
    bypass_sel_t srcSel;
    hzd_operand_match #(.RW(RW)) i_match (
      .decValid(decValid),
      .src     (decSrc[i]),
      .useSrc  (decUse[i]),
      .exValid (exValid),
      .exDst   (exDst),
      .exWrites(exWrites),
      .mmValid (mmValid),
      .mmDst   (mmDst),
      .mmWrites(mmWrites),
      .hitEx   (hitEx[i]),
      .hitMm   (hitMm[i]),
      .sel     (srcSel)
    );
    assign sel[i] = srcSel;

    AST_ZERO_REG_FROM_FILE: assert property (@(posedge clk) disable iff (!rstN)
      (decSrc[i] == '0) |-> (sel[i] == SEL_RF)); // R4
  end

  always_comb begin
    freeze    = dataMiss && mmValid && mmLoad && (|hitMm);
    longBusy  = exValid && exLong && !longDone;
    loadUse   = exValid && exLoad && (|hitEx);
    ctl       = '0;
    holdFront = 1'b0;
    if (freeze) begin
      holdFront   = 1'b1;
      ctl.holdEx  = 1'b1;
      ctl.holdMem = 1'b1;
    end else if (longBusy) begin
      holdFront     = 1'b1;
      ctl.holdEx    = 1'b1;
      ctl.bubbleMem = 1'b1;
    end else if (loadUse || fetchMiss) begin
      holdFront    = 1'b1;
      ctl.bubbleEx = 1'b1;
    end
  end

  AST_FREEZE_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdMem |-> !ctl.bubbleEx && !ctl.bubbleMem); // R11
  AST_EXEC_HOLD_NEEDS_FRONT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.holdEx || ctl.bubbleEx) |-> holdFront); // R7
endmodule

// File: rtl/hzd_stages.sv
module hzd_stages
  import hazard_pkg::*;
#(
  parameter int unsigned RW = REG_BITS,
  parameter int unsigned TW = TRAP_SRCS
) (
  input  logic          clk,
  input  logic          rstN,
  input  stage_info_t   decInfo,
  input  stage_ctl_t    ctl,
  input  logic [TW-1:0] trapReq,
  input  logic          exNullify,
  output stage_info_t   exInfo,
  output logic          mmValid,
  output logic [RW-1:0] mmDst,
  output logic          mmWrites,
  output logic          mmLoad,
  output logic          ctlWrite,
  output logic [TW-1:0] wbTrap
);
  stage_info_t   exQ;
  logic [TW-1:0] mmTrap;
  logic          wbValid;
  logic [TW-1:0] wbTrapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exQ      <= '0;
      mmValid  <= 1'b0;
      mmDst    <= '0;
      mmWrites <= 1'b0;
      mmLoad   <= 1'b0;
      mmTrap   <= '0;
      wbValid  <= 1'b0;
      wbTrapQ  <= '0;
    end else begin
      if (!ctl.holdMem) begin
        wbValid <= mmValid;
        wbTrapQ <= mmTrap;
        if (ctl.bubbleMem) begin
          mmValid  <= 1'b0;
          mmDst    <= '0;
          mmWrites <= 1'b0;
          mmLoad   <= 1'b0;
          mmTrap   <= '0;
        end else begin
          mmValid  <= exQ.valid;
          mmDst    <= exQ.dst;
          mmWrites <= exQ.writes;
          mmLoad   <= exQ.load;
          mmTrap   <= exQ.valid ? trapReq : '0;
        end
      end
      if (!ctl.holdEx) begin
        exQ <= ctl.bubbleEx ? '0 : decInfo;
      end
    end
  end

  assign exInfo   = exQ;
  assign ctlWrite = exQ.valid && exQ.ctlMove && !exNullify && !ctl.holdEx;
  assign wbTrap   = wbValid ? wbTrapQ : '0;

  AST_BUBBLE_EMPTIES_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bubbleEx && !ctl.holdEx) |=> !exQ.valid); // R5
  AST_EXEC_HELD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdEx |=> $stable(exQ)); // R7
  AST_MEM_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdMem |=> $stable(mmTrap) && $stable(wbTrapQ) && $stable(mmValid)); // R8
  AST_TRAP_ONLY_REAL: assert property (@(posedge clk) disable iff (!rstN)
    (wbTrap != '0) |-> wbValid); // R9
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 decValid,
  input  logic [REG_BITS-1:0]  decSrcA,
  input  logic                 decUseA,
  input  logic [REG_BITS-1:0]  decSrcB,
  input  logic                 decUseB,
  input  logic [REG_BITS-1:0]  decDst,
  input  logic                 decWrites,
  input  logic                 decLoad,
  input  logic                 decLong,
  input  logic                 decCtlMove,
  input  logic                 fetchMiss,
  input  logic                 dataMiss,
  input  logic                 longDone,
  input  logic                 exNullify,
  input  logic [TRAP_SRCS-1:0] trapReq,
  output logic [1:0]           bypassA,
  output logic [1:0]           bypassB,
  output logic                 holdFront,
  output logic                 holdExec,
  output logic                 holdMem,
  output logic                 bubbleExec,
  output logic                 bubbleMem,
  output logic                 ctlWrite,
  output logic [TRAP_SRCS-1:0] wbTrap
);
  stage_info_t                      decInfo;
  stage_info_t                      exInfo;
  stage_ctl_t                       ctl;
  logic                             mmValid, mmWrites, mmLoad;
  logic [REG_BITS-1:0]              mmDst;
  logic [NUM_SRC-1:0][1:0]          sel;

  assign decInfo = '{valid: decValid, dst: decDst, writes: decWrites,
                     load: decLoad, lengthy: decLong, ctlMove: decCtlMove};

  hzd_control #(.RW(REG_BITS), .NS(NUM_SRC)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .decValid (decValid),
    .decSrc   ({decSrcB, decSrcA}),
    .decUse   ({decUseB, decUseA}),
    .exValid  (exInfo.valid),
    .exDst    (exInfo.dst),
    .exWrites (exInfo.writes),
    .exLoad   (exInfo.load),
    .exLong   (exInfo.lengthy),
    .mmValid  (mmValid),
    .mmDst    (mmDst),
    .mmWrites (mmWrites),
    .mmLoad   (mmLoad),
    .fetchMiss(fetchMiss),
    .dataMiss (dataMiss),
    .longDone (longDone),
    .ctl      (ctl),
    .holdFront(holdFront),
    .sel      (sel)
  );

  hzd_stages #(.RW(REG_BITS), .TW(TRAP_SRCS)) i_stages (
    .clk      (clk),
    .rstN     (rstN),
    .decInfo  (decInfo),
    .ctl      (ctl),
    .trapReq  (trapReq),
    .exNullify(exNullify),
    .exInfo   (exInfo),
    .mmValid  (mmValid),
    .mmDst    (mmDst),
    .mmWrites (mmWrites),
    .mmLoad   (mmLoad),
    .ctlWrite (ctlWrite),
    .wbTrap   (wbTrap)
  );

  assign bypassA    = sel[0];
  assign bypassB    = sel[1];
  assign holdExec   = ctl.holdEx;
  assign holdMem    = ctl.holdMem;
  assign bubbleExec = ctl.bubbleEx;
  assign bubbleMem  = ctl.bubbleMem;
endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 0, decUseA = 0, decUseB = 0, decWrites = 0, decLoad = 0;
  logic decLong = 0, decCtlMove = 0, fetchMiss = 0, dataMiss = 0;
  logic longDone = 0, exNullify = 0;
  logic [4:0] decSrcA = 0, decSrcB = 0, decDst = 0;
  logic [3:0] trapReq = 0;
  logic [1:0] bypassA, bypassB;
  logic holdFront, holdExec, holdMem, bubbleExec, bubbleMem, ctlWrite;
  logic [3:0] wbTrap;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hazard_unit i_hazard_unit (.*);

  typedef struct {
    bit v; int a; bit ua; int b; bit ub; int d; bit wr; bit ld; bit lg; bit ct;
  } dec_t;
  typedef struct { bit v; int dst; bit wr; bit ld; bit lg; bit ct; int trap; } ent_t;

  ent_t pipe[$];

  function automatic dec_t mk(bit v, int a, bit ua, int b, bit ub, int d,
                              bit wr, bit ld, bit lg, bit ct);
    dec_t r;
    r.v = v; r.a = a; r.ua = ua; r.b = b; r.ub = ub; r.d = d;
    r.wr = wr; r.ld = ld; r.lg = lg; r.ct = ct;
    return r;
  endfunction

  function automatic ent_t blank();
    ent_t e;
    e.v = 0; e.dst = 0; e.wr = 0; e.ld = 0; e.lg = 0; e.ct = 0; e.trap = 0;
    return e;
  endfunction

  task automatic chk(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit hit(ent_t e, dec_t d, int s, bit u);
    return d.v && u && s != 0 && e.v && e.wr && e.dst == s;
  endfunction

  task automatic step(dec_t d, bit fm, bit dm, bit ldn, bit nul, int tr, string tag);
    bit eFront, eHEx, eHMem, eBEx, eBMem, frz, lng, lu;
    int selA, selB;
    ent_t ex, mm, wb, n;
    decValid = d.v; decSrcA = 5'(d.a); decUseA = d.ua; decSrcB = 5'(d.b); decUseB = d.ub;
    decDst = 5'(d.d); decWrites = d.wr; decLoad = d.ld; decLong = d.lg; decCtlMove = d.ct;
    fetchMiss = fm; dataMiss = dm; longDone = ldn; exNullify = nul; trapReq = 4'(tr);
    #1;
    ex = pipe[0]; mm = pipe[1]; wb = pipe[2];
    selA = hit(ex, d, d.a, d.ua) ? 1 : hit(mm, d, d.a, d.ua) ? 2 : 0;
    selB = hit(ex, d, d.b, d.ub) ? 1 : hit(mm, d, d.b, d.ub) ? 2 : 0;
    frz = dm && mm.v && mm.ld && (hit(mm, d, d.a, d.ua) || hit(mm, d, d.b, d.ub));
    lng = ex.v && ex.lg && !ldn;
    lu  = ex.v && ex.ld && (hit(ex, d, d.a, d.ua) || hit(ex, d, d.b, d.ub));
    eFront = frz || lng || lu || fm;
    eHEx = frz || lng;
    eHMem = frz;
    eBEx = !frz && !lng && (lu || fm);
    eBMem = !frz && lng;
    chk(bypassA, selA, tag, "bypassA");
    chk(bypassB, selB, tag, "bypassB");
    chk(holdFront, eFront, tag, "holdFront");
    chk(holdExec, eHEx, tag, "holdExec");
    chk(holdMem, eHMem, tag, "holdMem");
    chk(bubbleExec, eBEx, tag, "bubbleExec");
    chk(bubbleMem, eBMem, tag, "bubbleMem");
    chk(ctlWrite, ex.v && ex.ct && !nul && !eHEx, tag, "ctlWrite");
    chk(wbTrap, wb.v ? wb.trap : 0, tag, "wbTrap");
    @(posedge clk);
    if (!eHMem) begin
      pipe[2] = pipe[1];
      if (eBMem) pipe[1] = blank();
      else begin
        pipe[1] = pipe[0];
        pipe[1].trap = pipe[0].v ? tr : 0;
      end
    end
    if (!eHEx) begin
      if (eBEx) pipe[0] = blank();
      else begin
        n.v = d.v; n.dst = d.d; n.wr = d.wr; n.ld = d.ld; n.lg = d.lg; n.ct = d.ct; n.trap = 0;
        pipe[0] = n;
      end
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    dec_t nop, useR3;
    nop = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) pipe.push_back(blank());
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(bypassA, 0, "R1", "bypassA"); chk(bypassB, 0, "R1", "bypassB");
    chk(holdFront, 0, "R1", "holdFront"); chk(holdExec, 0, "R1", "holdExec");
    chk(holdMem, 0, "R1", "holdMem"); chk(bubbleExec, 0, "R1", "bubbleExec");
    chk(bubbleMem, 0, "R1", "bubbleMem"); chk(ctlWrite, 0, "R1", "ctlWrite");
    chk(wbTrap, 0, "R1", "wbTrap");
    rstN = 1'b1;
    step(nop, 0, 0, 0, 0, 0, "R1");

    // R2: execute forwarding
    step(mk(1, 1, 1, 2, 1, 3, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R2");
    useR3 = mk(1, 3, 1, 0, 0, 4, 1, 0, 0, 0);
    step(useR3, 0, 0, 0, 0, 0, "R2");
    // R3: memory forwarding and execute priority
    step(mk(1, 3, 1, 4, 1, 5, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R3");
    step(mk(1, 1, 1, 1, 1, 6, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R3");
    step(mk(1, 1, 1, 1, 1, 6, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R3");
    step(mk(1, 6, 1, 6, 1, 7, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R3");

    // R4: register 0, unused source, writeback producer
    step(mk(1, 1, 1, 1, 1, 0, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R4");
    step(mk(1, 0, 1, 7, 0, 8, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R4");
    step(nop, 0, 0, 0, 0, 0, "R4");
    step(nop, 0, 0, 0, 0, 0, "R4");
    step(mk(1, 8, 1, 8, 1, 9, 0, 0, 0, 0), 0, 0, 0, 0, 0, "R4");

    // R5: load-use bubble, then memory forwarding
    step(mk(1, 1, 1, 0, 0, 9, 1, 1, 0, 0), 0, 0, 0, 0, 0, "R5");
    step(mk(1, 2, 1, 9, 1, 10, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R5");
    step(mk(1, 2, 1, 9, 1, 10, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R5");

    // R6: instruction-cache miss
    step(useR3, 1, 0, 0, 0, 0, "R6");
    step(useR3, 1, 0, 0, 0, 0, "R6");
    step(useR3, 0, 0, 0, 0, 0, "R6");

    // R7: long instruction held in execute
    step(mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 0), 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 3; i++) step(useR3, 0, 0, 0, 0, 0, "R7");
    step(useR3, 0, 0, 1, 0, 0, "R7");
    step(nop, 0, 0, 0, 0, 0, "R7");

    // R8: dependent data miss freezes, independent one does not
    step(mk(1, 0, 0, 0, 0, 11, 1, 1, 0, 0), 0, 0, 0, 0, 0, "R8");
    step(nop, 0, 0, 0, 0, 0, "R8");
    step(mk(1, 11, 1, 0, 0, 12, 1, 0, 0, 0), 0, 1, 0, 0, 0, "R8");
    step(mk(1, 11, 1, 0, 0, 12, 1, 0, 0, 0), 0, 1, 0, 0, 0, "R8");
    step(mk(1, 11, 1, 0, 0, 12, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R8");
    step(mk(1, 0, 0, 0, 0, 13, 1, 1, 0, 0), 0, 0, 0, 0, 0, "R8");
    step(nop, 0, 0, 0, 0, 0, "R8");
    step(mk(1, 2, 1, 4, 1, 14, 1, 0, 0, 0), 0, 1, 0, 0, 0, "R8");

    // R9: trap requests carried to writeback
    step(mk(1, 0, 0, 0, 0, 15, 1, 0, 0, 0), 0, 0, 0, 0, 0, "R9");
    step(nop, 0, 0, 0, 0, 5, "R9");
    step(nop, 0, 0, 0, 0, 10, "R9");
    step(nop, 0, 0, 0, 0, 15, "R9");
    step(nop, 0, 0, 0, 0, 0, "R9");

    // R10: control move write, plain and nullified
    step(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 1), 0, 0, 0, 0, 0, "R10");
    step(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 1), 0, 0, 0, 0, 0, "R10");
    step(nop, 0, 0, 0, 1, 0, "R10");

    // R11: priority between stall causes
    step(mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 0), 0, 0, 0, 0, 0, "R11");
    step(useR3, 1, 0, 0, 0, 0, "R11");
    step(useR3, 1, 0, 1, 0, 0, "R11");
    step(mk(1, 0, 0, 0, 0, 16, 1, 1, 0, 0), 0, 0, 0, 0, 0, "R11");
    step(mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 0), 0, 0, 0, 0, 0, "R11");
    step(mk(1, 16, 1, 0, 0, 17, 1, 0, 0, 0), 1, 1, 0, 0, 0, "R11");
    step(mk(1, 16, 1, 0, 0, 17, 1, 0, 0, 0), 1, 0, 0, 0, 0, "R11");
    step(mk(1, 16, 1, 0, 0, 17, 1, 0, 0, 0), 0, 0, 1, 0, 0, "R11");
    for (int i = 0; i < 4; i++) step(nop, 0, 0, 0, 0, 0, "R11");

    finish_run();
  end
endmodule